// File: doc/BRIEF.md
# DMA Payload Mover with Pattern Fill

This block is the payload engine of one DMA channel. A sequencer hands it a source descriptor (address, byte count) and a first destination descriptor (address, byte count, interrupt flag), plus a transfer mode and an addressing style for each side. The mover then cuts the source into chunks no larger than a staging buffer and, for each chunk, issues a read command and one or more write commands to the memory ports. The data itself moves through a staging buffer in the datapath next to the mover. In fill mode the source is never read and every write carries a bus-wide pattern word. In read-only mode the source is read and nothing is written.

The destination side is consumed on its own terms: a single chunk may be spread over several destination descriptors. When descriptors are held in memory, the mover asks the sequencer for the next destination descriptor each time the current one runs dry. A running byte total counts every chunk, and software clears bits of it by writing ones. Pulses report the end of the source and the emptying of a destination descriptor that asked for an interrupt.

Top module: `dma_payload_mover`

## Requirements
- R1: Mode code 0 (copy) reads every source byte once and writes the same number of bytes to the destination; mode code 3 behaves as copy.
- R2: Mode code 1 (fill) takes its length from the destination descriptor size, never asserts a read, writes at most BUS_BYTES per write with `wr_fill` high, and presents the latched `fill_pattern` on `wr_pattern`.
- R3: Mode code 2 (read-only) reads the whole source and never asserts `wr_valid`.
- R4: An addressing bit of 1 (fixed) caps each access on that side at BUS_BYTES and repeats the same address; a bit of 0 (incrementing) advances the address by each access length.
- R5: With `cfg_mem_dscr` high, the mode is treated as copy and both sides as incrementing, whatever the mode and fixed bits say.
- R6: A chunk, and hence each read length, is the smaller of the remaining source bytes and CHUNK_BYTES (and of BUS_BYTES when fill mode or fixed reads apply).
- R7: With memory-held descriptors, a destination size of zero raises `dsc_req` until `dsc_valid`, loads the returned descriptor, and writing resumes at its address; a fetched size of zero is fetched past.
- R8: With register-held descriptors outside fill mode, the destination size is taken to be the unwritten rest of the current chunk, so each chunk is written out in full.
- R9: `total_bytes` adds each chunk length when the chunk completes; bits set in `total_clr` are cleared in the same cycle, before the addition.
- R10: `done` pulses for one cycle when the remaining source count reaches zero; a zero source length ends the job with no access and no `done`.
- R11: `dst_done` pulses after a write that brings a destination descriptor's size to zero when its interrupt flag is set, and only then.
- R12: A request held while its ready is low keeps its valid, address and length unchanged; reads and writes are never requested at once.
- R13: After reset the mover is idle with no request, no pulse and a total of zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a job with the cfg_* values (taken while idle) |
| cfg_mode | input | 2 | 0 copy, 1 fill, 2 read-only, 3 copy |
| cfg_mem_dscr | input | 1 | Descriptors held in memory (forces copy, incrementing) |
| cfg_rd_fixed | input | 1 | Source addressing: 1 fixed, 0 incrementing |
| cfg_wr_fixed | input | 1 | Destination addressing: 1 fixed, 0 incrementing |
| cfg_src_addr | input | ADDR_W | Source start address |
| cfg_src_size | input | SIZE_W | Source byte count |
| cfg_dst_addr | input | ADDR_W | First destination address |
| cfg_dst_size | input | SIZE_W | First destination byte count |
| cfg_dst_intr | input | 1 | First destination interrupt flag |
| fill_pattern | input | BUS_W | Pattern word for fill mode |
| busy | output | 1 | Job in progress |
| rd_valid | output | 1 | Read command valid |
| rd_ready | input | 1 | Read command accepted |
| rd_addr | output | ADDR_W | Read address |
| rd_len | output | SIZE_W | Read length in bytes |
| wr_valid | output | 1 | Write command valid |
| wr_ready | input | 1 | Write command accepted |
| wr_addr | output | ADDR_W | Write address |
| wr_len | output | SIZE_W | Write length in bytes |
| wr_fill | output | 1 | Write data is the pattern word |
| wr_pattern | output | BUS_W | Pattern word for fill writes |
| dsc_req | output | 1 | Request for the next destination descriptor |
| dsc_valid | input | 1 | Next destination descriptor present |
| dsc_addr | input | ADDR_W | Fetched descriptor address |
| dsc_size | input | SIZE_W | Fetched descriptor byte count |
| dsc_intr | input | 1 | Fetched descriptor interrupt flag |
| done | output | 1 | Source finished pulse |
| dst_done | output | 1 | Destination descriptor finished pulse |
| total_clr | input | TOT_W | Write-one-to-clear mask for the byte total |
| total_bytes | output | TOT_W | Running byte total |

## Verification
The hardest case to reach is a destination descriptor running dry in the middle of a chunk, with the next one fetched while the memory ports stall, including a fetched descriptor of size zero. The bench uses a 16-byte chunk and a 4-byte bus so that short sources already span several chunks, and answers fetches from a computed table whose sizes are small, unaligned to the chunk and zero for every fourth entry. Ready signals follow a cycle-based stall pattern on alternate jobs, and a reference model in the bench predicts every read, write, fetch and pulse.

// File: rtl/dma_mover_pkg.sv
package dma_mover_pkg;
  typedef enum logic [1:0] {
    XFER_COPY  = 2'd0,
    XFER_FILL  = 2'd1,
    XFER_RONLY = 2'd2,
    XFER_COPY2 = 2'd3
  } xfer_mode_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_CHUNK,
    S_READ,
    S_WPLAN,
    S_WRITE,
    S_FETCH,
    S_ACCT
  } mover_state_e;
endpackage

// File: rtl/dma_len_clip.sv
module dma_len_clip #(
  parameter int SIZE_W    = 30,
  parameter int BUS_BYTES = 8
) (
  input  logic [SIZE_W-1:0] avail,
  input  logic [SIZE_W-1:0] cap,
  input  logic              beat_lim,
  output logic [SIZE_W-1:0] len
);
  localparam logic [SIZE_W-1:0] BEAT = SIZE_W'(BUS_BYTES);
  logic [SIZE_W-1:0] lesser;

  always_comb begin
    lesser = (avail < cap) ? avail : cap;
    len    = (beat_lim && lesser > BEAT) ? BEAT : lesser;
  end
endmodule

// File: rtl/dma_byte_total.sv
module dma_byte_total #(
  parameter int SIZE_W = 30,
  parameter int TOT_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              add_en,
  input  logic [SIZE_W-1:0] add_len,
  input  logic [TOT_W-1:0]  clr_mask,
  output logic [TOT_W-1:0]  total
);
  logic [TOT_W-1:0] addend;
  assign addend = add_en ? TOT_W'(add_len) : '0;

  always_ff @(posedge clk) begin
    if (rst) total <= '0;
    else     total <= (total & ~clr_mask) + addend;
  end
endmodule

// File: rtl/dma_payload_mover.sv
module dma_payload_mover
  import dma_mover_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int SIZE_W      = 30,
  parameter int BUS_BYTES   = 8,
  parameter int CHUNK_BYTES = 2048,
  parameter int TOT_W       = 32,
  localparam int BUS_W      = BUS_BYTES * 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [1:0]        cfg_mode,
  input  logic              cfg_mem_dscr,
  input  logic              cfg_rd_fixed,
  input  logic              cfg_wr_fixed,
  input  logic [ADDR_W-1:0] cfg_src_addr,
  input  logic [SIZE_W-1:0] cfg_src_size,
  input  logic [ADDR_W-1:0] cfg_dst_addr,
  input  logic [SIZE_W-1:0] cfg_dst_size,
  input  logic              cfg_dst_intr,
  input  logic [BUS_W-1:0]  fill_pattern,
  output logic              busy,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [SIZE_W-1:0] rd_len,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [SIZE_W-1:0] wr_len,
  output logic              wr_fill,
  output logic [BUS_W-1:0]  wr_pattern,
  output logic              dsc_req,
  input  logic              dsc_valid,
  input  logic [ADDR_W-1:0] dsc_addr,
  input  logic [SIZE_W-1:0] dsc_size,
  input  logic              dsc_intr,
  output logic              done,
  output logic              dst_done,
  input  logic [TOT_W-1:0]  total_clr,
  output logic [TOT_W-1:0]  total_bytes
);
  localparam logic [SIZE_W-1:0] CHUNK_LEN = SIZE_W'(CHUNK_BYTES);

  mover_state_e      state;
  logic              fill_m, ronly_m, mem_m, rfix_m, wfix_m;
  logic [ADDR_W-1:0] src_addr_q, dst_addr_q;
  logic [SIZE_W-1:0] src_rem, dst_size_q, chunk_len, wr_rem;
  logic              dst_intr_q, pend_dd;
  logic [BUS_W-1:0]  pattern_q;

  // effective settings of a new job: memory descriptors force copy/incrementing
  logic start_fill, start_ronly;
  assign start_fill  = !cfg_mem_dscr && (cfg_mode == XFER_FILL);
  assign start_ronly = !cfg_mem_dscr && (cfg_mode == XFER_RONLY);

  logic [SIZE_W-1:0] clen, wlen, dsize_eff, dst_left;
  assign dsize_eff = (!mem_m && !fill_m) ? wr_rem : dst_size_q;
  assign dst_left  = dsize_eff - wlen;

  dma_len_clip #(.SIZE_W(SIZE_W), .BUS_BYTES(BUS_BYTES)) u_chunk_clip (
    .avail(src_rem), .cap(CHUNK_LEN), .beat_lim(rfix_m || fill_m), .len(clen)
  );

  dma_len_clip #(.SIZE_W(SIZE_W), .BUS_BYTES(BUS_BYTES)) u_write_clip (
    .avail(wr_rem), .cap(dsize_eff), .beat_lim(wfix_m), .len(wlen)
  );

  dma_byte_total #(.SIZE_W(SIZE_W), .TOT_W(TOT_W)) u_total (
    .clk(clk), .rst(rst), .add_en(state == S_ACCT), .add_len(chunk_len),
    .clr_mask(total_clr), .total(total_bytes)
  );

  assign busy       = (state != S_IDLE);
  assign wr_fill    = fill_m;
  assign wr_pattern = pattern_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_IDLE;
      fill_m     <= 1'b0;
      ronly_m    <= 1'b0;
      mem_m      <= 1'b0;
      rfix_m     <= 1'b0;
      wfix_m     <= 1'b0;
      src_addr_q <= '0;
      dst_addr_q <= '0;
      src_rem    <= '0;
      dst_size_q <= '0;
      dst_intr_q <= 1'b0;
      chunk_len  <= '0;
      wr_rem     <= '0;
      pend_dd    <= 1'b0;
      pattern_q  <= '0;
      rd_valid   <= 1'b0;
      rd_addr    <= '0;
      rd_len     <= '0;
      wr_valid   <= 1'b0;
      wr_addr    <= '0;
      wr_len     <= '0;
      dsc_req    <= 1'b0;
      done       <= 1'b0;
      dst_done   <= 1'b0;
    end else begin
      done     <= 1'b0;
      dst_done <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          fill_m     <= start_fill;
          ronly_m    <= start_ronly;
          mem_m      <= cfg_mem_dscr;
          rfix_m     <= !cfg_mem_dscr && cfg_rd_fixed;
          wfix_m     <= !cfg_mem_dscr && cfg_wr_fixed;
          src_addr_q <= cfg_src_addr;
          src_rem    <= start_fill ? cfg_dst_size : cfg_src_size;
          dst_addr_q <= cfg_dst_addr;
          dst_size_q <= cfg_dst_size;
          dst_intr_q <= cfg_dst_intr;
          pattern_q  <= fill_pattern;
          state      <= S_CHUNK;
        end
        S_CHUNK: begin
          if (src_rem == '0) begin
            state <= S_IDLE;
          end else begin
            chunk_len <= clen;
            wr_rem    <= clen;
            if (fill_m) begin
              state <= S_WPLAN;
            end else begin
              rd_valid <= 1'b1;
              rd_addr  <= src_addr_q;
              rd_len   <= clen;
              state    <= S_READ;
            end
          end
        end
        S_READ: if (rd_ready) begin
          rd_valid <= 1'b0;
          if (!rfix_m) src_addr_q <= src_addr_q + ADDR_W'(rd_len);
          state <= ronly_m ? S_ACCT : S_WPLAN;
        end
        S_WPLAN: begin
          if (mem_m && dst_size_q == '0) begin
            dsc_req <= 1'b1;
            state   <= S_FETCH;
          end else begin
            wr_valid   <= 1'b1;
            wr_addr    <= dst_addr_q;
            wr_len     <= wlen;
            dst_size_q <= dst_left;
            wr_rem     <= wr_rem - wlen;
            pend_dd    <= (dst_left == '0) && dst_intr_q;
            state      <= S_WRITE;
          end
        end
        S_WRITE: if (wr_ready) begin
          wr_valid <= 1'b0;
          if (!wfix_m) dst_addr_q <= dst_addr_q + ADDR_W'(wr_len);
          dst_done <= pend_dd;
          pend_dd  <= 1'b0;
          state    <= (wr_rem == '0) ? S_ACCT : S_WPLAN;
        end
        S_FETCH: if (dsc_valid) begin
          dsc_req    <= 1'b0;
          dst_addr_q <= dsc_addr;
          dst_size_q <= dsc_size;
          dst_intr_q <= dsc_intr;
          state      <= S_WPLAN;
        end
        S_ACCT: begin
          src_rem <= src_rem - chunk_len;
          if (src_rem == chunk_len) begin
            done  <= 1'b1;
            state <= S_IDLE;
          end else begin
            state <= S_CHUNK;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dma_mover_chk.sv
module dma_mover_chk #(
  parameter int ADDR_W    = 32,
  parameter int SIZE_W    = 30,
  parameter int BUS_BYTES = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              rd_valid,
  input logic              rd_ready,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [SIZE_W-1:0] rd_len,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [SIZE_W-1:0] wr_len,
  input logic              done,
  input logic              fill_m,
  input logic              ronly_m,
  input logic              wfix_m
);
  localparam logic [SIZE_W-1:0] BEAT = SIZE_W'(BUS_BYTES);

  // R12
  rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_addr) && $stable(rd_len));

  // R12
  wr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_len));

  // R12
  no_overlap_chk: assert property (@(posedge clk) disable iff (rst)
    !(rd_valid && wr_valid));

  // R3
  ronly_no_write_chk: assert property (@(posedge clk) disable iff (rst)
    ronly_m |-> !wr_valid);

  // R2
  fill_no_read_chk: assert property (@(posedge clk) disable iff (rst)
    fill_m |-> !rd_valid);

  // R4
  fixed_beat_chk: assert property (@(posedge clk) disable iff (rst)
    wr_valid && wfix_m |-> wr_len <= BEAT && wr_len != '0);

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

bind dma_payload_mover dma_mover_chk #(
  .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .BUS_BYTES(BUS_BYTES)
) u_mover_chk (
  .clk(clk), .rst(rst),
  .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr), .rd_len(rd_len),
  .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_len(wr_len),
  .done(done), .fill_m(fill_m), .ronly_m(ronly_m), .wfix_m(wfix_m)
);

// File: tb/test_dma_payload_mover.sv
module test_dma_payload_mover;
  localparam int AW = 16;
  localparam int SW = 12;
  localparam int BB = 4;
  localparam int CB = 16;
  localparam int TW = 32;
  localparam int BW = BB * 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [1:0]    cfg_mode = '0;
  logic          cfg_mem_dscr = 1'b0, cfg_rd_fixed = 1'b0, cfg_wr_fixed = 1'b0;
  logic [AW-1:0] cfg_src_addr = '0, cfg_dst_addr = '0;
  logic [SW-1:0] cfg_src_size = '0, cfg_dst_size = '0;
  logic          cfg_dst_intr = 1'b0;
  logic [BW-1:0] fill_pattern = '0;
  logic          busy, rd_valid, wr_valid, wr_fill, dsc_req, done, dst_done;
  logic          rd_ready = 1'b0, wr_ready = 1'b0, dsc_valid = 1'b0, dsc_intr = 1'b0;
  logic [AW-1:0] rd_addr, wr_addr;
  logic [AW-1:0] dsc_addr = '0;
  logic [SW-1:0] rd_len, wr_len;
  logic [SW-1:0] dsc_size = '0;
  logic [BW-1:0] wr_pattern;
  logic [TW-1:0] total_clr = '0;
  logic [TW-1:0] total_bytes;

  always #5 clk = ~clk;

  dma_payload_mover #(.ADDR_W(AW), .SIZE_W(SW), .BUS_BYTES(BB),
                      .CHUNK_BYTES(CB), .TOT_W(TW)) i_dma_payload_mover (
    .clk(clk), .rst(rst), .start(start), .cfg_mode(cfg_mode),
    .cfg_mem_dscr(cfg_mem_dscr), .cfg_rd_fixed(cfg_rd_fixed), .cfg_wr_fixed(cfg_wr_fixed),
    .cfg_src_addr(cfg_src_addr), .cfg_src_size(cfg_src_size),
    .cfg_dst_addr(cfg_dst_addr), .cfg_dst_size(cfg_dst_size), .cfg_dst_intr(cfg_dst_intr),
    .fill_pattern(fill_pattern), .busy(busy),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr), .rd_len(rd_len),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_len(wr_len),
    .wr_fill(wr_fill), .wr_pattern(wr_pattern),
    .dsc_req(dsc_req), .dsc_valid(dsc_valid), .dsc_addr(dsc_addr), .dsc_size(dsc_size),
    .dsc_intr(dsc_intr), .done(done), .dst_done(dst_done),
    .total_clr(total_clr), .total_bytes(total_bytes)
  );

  int  nchk = 0, nerr = 0;
  bit  finished = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // reference model state (effective settings)
  int          m_mode;   // 0 copy, 1 fill, 2 read-only
  bit          m_mem, m_rfix, m_wfix, m_dintr;
  int          m_src_rem, m_chunk_rem, m_dsize, m_rd_bytes, m_wr_bytes;
  logic [AW-1:0] m_saddr, m_daddr;
  int          exp_dd, seen_dd, seen_done, fetch_idx, stall_sel, cyc;
  longint      exp_total;

  function automatic int clip(input int avail, input int cap, input bit lim);
    int v;
    v = (avail < cap) ? avail : cap;
    if (lim && v > BB) v = BB;
    return v;
  endfunction

  function automatic bit rdy(input int salt);
    return (stall_sel == 0) ? 1'b1 : (((cyc * 7 + salt) % 5) < 3);
  endfunction

  always @(negedge clk) begin
    int el, eff;
    cyc++;
    rd_ready  = rdy(0);
    wr_ready  = rdy(2);
    dsc_valid = dsc_req && rdy(4);
    dsc_addr  = AW'(16'h4000 + fetch_idx * 16'h40);
    dsc_size  = SW'(((fetch_idx % 4) == 1) ? 0 : 3 + (fetch_idx * 5) % 9);
    dsc_intr  = (fetch_idx % 2) == 0;
    if (done) seen_done++;
    if (dst_done) seen_dd++;
    if (!rst) begin
      if (dsc_req && dsc_valid) begin
        // R7: fetched descriptor replaces the exhausted one
        chk(m_mem && m_dsize == 0, "R7", "fetch only when dst empty", m_dsize, 0);
        m_daddr = dsc_addr; m_dsize = int'(dsc_size); m_dintr = dsc_intr;
        fetch_idx++;
      end
      if (rd_valid && rd_ready) begin
        el = clip(m_src_rem, CB, m_rfix);
        chk(m_mode != 1, "R2", "read in fill mode", 1, 0);
        chk(rd_addr == m_saddr, "R4", "read address", rd_addr, m_saddr);
        chk(int'(rd_len) == el, "R6", "read length", rd_len, el);
        m_src_rem -= int'(rd_len);
        m_rd_bytes += int'(rd_len);
        if (!m_rfix) m_saddr = m_saddr + AW'(rd_len);
        m_chunk_rem = (m_mode == 2) ? 0 : int'(rd_len);
      end
      if (wr_valid && wr_ready) begin
        chk(m_mode != 2, "R3", "write in read-only mode", 1, 0);
        if (m_mode == 1 && m_chunk_rem == 0) begin
          m_chunk_rem = clip(m_src_rem, CB, 1'b1);
          m_src_rem -= m_chunk_rem;
        end
        // R8: register descriptors outside fill use the chunk rest as dst size
        eff = (!m_mem && m_mode != 1) ? m_chunk_rem : m_dsize;
        el  = clip(m_chunk_rem, eff, m_wfix);
        chk(wr_addr == m_daddr, "R4", "write address", wr_addr, m_daddr);
        chk(int'(wr_len) == el, "R8", "write length", wr_len, el);
        chk(wr_fill == (m_mode == 1), "R2", "fill flag", wr_fill, m_mode == 1);
        if (m_mode == 1)
          chk(wr_pattern == fill_pattern, "R2", "pattern", wr_pattern, fill_pattern);
        m_dsize = eff - el;
        if (m_dsize == 0 && m_dintr) exp_dd++;
        if (!m_wfix) m_daddr = m_daddr + AW'(wr_len);
        m_chunk_rem -= el;
        m_wr_bytes += int'(wr_len);
      end
    end
  end

  task automatic run(input int mode, input bit mem, input bit rf, input bit wf,
                     input int ssize, input int dsize, input bit dintr);
    int eff_mode, job_len;
    @(negedge clk);
    eff_mode = mem ? 0 : ((mode == 3) ? 0 : mode);
    job_len  = (eff_mode == 1) ? dsize : ssize;
    cfg_mode = 2'(mode); cfg_mem_dscr = mem; cfg_rd_fixed = rf; cfg_wr_fixed = wf;
    cfg_src_addr = AW'(16'h1000 + ssize * 3); cfg_dst_addr = AW'(16'h2000 + dsize * 5);
    cfg_src_size = SW'(ssize); cfg_dst_size = SW'(dsize); cfg_dst_intr = dintr;
    fill_pattern = BW'(32'hA5C3_0000 + ssize * 17 + dsize);
    m_mode = eff_mode; m_mem = mem; m_rfix = rf && !mem; m_wfix = wf && !mem;
    m_src_rem = job_len; m_chunk_rem = 0; m_dsize = dsize; m_dintr = dintr;
    m_saddr = cfg_src_addr; m_daddr = cfg_dst_addr;
    m_rd_bytes = 0; m_wr_bytes = 0; exp_dd = 0; seen_dd = 0; seen_done = 0;
    exp_total += job_len;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (busy) @(negedge clk);
    @(negedge clk);
    // R10: one done pulse when the source empties, none for an empty job
    chk(seen_done == (job_len > 0 ? 1 : 0), "R10", "done pulses", seen_done, job_len > 0);
    // R11
    chk(seen_dd == exp_dd, "R11", "dst_done pulses", seen_dd, exp_dd);
    // R9
    chk(total_bytes == TW'(exp_total), "R9", "total bytes", total_bytes, exp_total);
    chk(m_src_rem == 0, "R1", "source bytes left", m_src_rem, 0);
    if (eff_mode == 0) begin
      // R1, R5: copy moves equal byte counts
      chk(m_rd_bytes == ssize, "R1", "bytes read", m_rd_bytes, ssize);
      chk(m_wr_bytes == ssize, "R5", "bytes written", m_wr_bytes, ssize);
    end else if (eff_mode == 1) begin
      chk(m_rd_bytes == 0 && m_wr_bytes == dsize, "R2", "fill bytes", m_wr_bytes, dsize);
    end else begin
      chk(m_wr_bytes == 0 && m_rd_bytes == ssize, "R3", "read-only bytes", m_rd_bytes, ssize);
    end
  endtask

  task automatic clear_total(input logic [TW-1:0] mask);
    @(negedge clk);
    total_clr = mask;
    @(negedge clk);
    total_clr = '0;
    exp_total = exp_total & ~longint'(mask);
    chk(total_bytes == TW'(exp_total), "R9", "total after clear", total_bytes, exp_total);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nerr++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    int sizes[6];
    sizes = '{1, 4, 5, 16, 17, 37};
    cyc = 0; fetch_idx = 0; stall_sel = 0; exp_total = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R13
    chk(!busy && !rd_valid && !wr_valid && !dsc_req, "R13", "idle after reset", busy, 0);
    chk(!done && !dst_done, "R13", "no pulse after reset", done, 0);
    chk(total_bytes == '0, "R13", "total after reset", total_bytes, 0);

    // R10: empty jobs
    run(0, 1'b0, 1'b0, 1'b0, 0, 8, 1'b1);
    run(1, 1'b0, 1'b0, 1'b0, 9, 0, 1'b1);

    // register descriptors: every mode and addressing style
    for (int mode = 0; mode < 4; mode++)
      for (int fx = 0; fx < 4; fx++)
        for (int si = 0; si < 6; si++) begin
          stall_sel = (si + fx) % 2;
          run(mode, 1'b0, fx[0], fx[1], sizes[si], sizes[5 - si], (si % 2) == 0);
        end

    clear_total(32'h0000_00F0);

    // R5, R7: memory descriptors with chaining, forcing of mode and addressing
    for (int mode = 0; mode < 3; mode++)
      for (int si = 0; si < 6; si++)
        for (int d0 = 0; d0 < 2; d0++) begin
          stall_sel = (si + d0 + mode) % 2;
          run(mode, 1'b1, 1'b1, 1'b1, sizes[si] + 3 * mode, d0 * 6, 1'b1);
        end

    clear_total('1);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule